// File: doc/BRIEF.md
# CAN Bus-Off Recovery Sequencer

This block runs the wait that a CAN node must serve after it has gone bus-off. When the protocol engine signals bus-off, the sequencer raises the node's init control bit by itself, which halts all bus traffic. Nothing more happens until the host writes that bit back to zero. From then on the sequencer watches the sampled bus level on every bit-time strobe and counts runs of consecutive recessive bits. Each complete run of eleven recessive bits counts as one bus-idle occurrence. Once 129 such occurrences have been seen, the node may rejoin the bus.

Each completed run raises a one-cycle strobe that tells the status logic to record the bit0-error code, so software can follow the progress. The running number of completed runs is exposed on an output that the register file maps onto the receive error counter field. The final run raises a one-cycle pulse that clears the error management counters and returns the block to normal operation. Host writes to init while recovery is running are ignored, so the host cannot shorten the wait.

Top module: `bor_recovery`

## Requirements
- R1: After reset, `init_o` is 0, `rec_seq_cnt` is 0, and `lec_wr_stb`, `lec_wr_code` and `err_cnt_clr` are all 0.
- R2: A cycle with `busoff_enter` high sets `init_o` to 1 at the next clock edge, whatever the host writes in the same cycle.
- R3: While `init_o` stays set after bus-off entry, recessive bits are not counted: `rec_seq_cnt` stays 0 and `lec_wr_stb` stays 0.
- R4: While halted after bus-off, a host write of 0 (`init_wr` high, `init_wdata` 0) clears `init_o` and starts counting. A host write of 1 leaves the block halted.
- R5: During recovery, every 11th consecutive recessive bit (`bus_bit`=1 with `bit_stb` high) raises `lec_wr_stb` for exactly one cycle, with `lec_wr_code` equal to 3'b101, and adds 1 to `rec_seq_cnt` on the same edge.
- R6: A dominant bit (`bus_bit`=0 with `bit_stb` high) during recovery discards the current partial run and leaves `rec_seq_cnt` unchanged.
- R7: Runs do not overlap. After a completed run, the next run starts from zero, so 22 consecutive recessive bits give exactly two increments.
- R8: `bus_bit` is ignored in cycles where `bit_stb` is low. Such cycles neither extend nor break a run.
- R9: The 129th completed run raises `err_cnt_clr` for exactly one cycle, returns `rec_seq_cnt` to 0 and ends recovery. `rec_seq_cnt` never exceeds 128.
- R10: During recovery, host writes to init are ignored: `init_o` stays 0 and counting continues without loss.
- R11: A `busoff_enter` during recovery restarts the procedure: `init_o` becomes 1 and `rec_seq_cnt` becomes 0.
- R12: Outside bus-off handling, a host write copies `init_wdata` into `init_o` on the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_stb | input | 1 | One-cycle strobe marking a sampled bit time |
| bus_bit | input | 1 | Sampled bus level, 1 = recessive |
| busoff_enter | input | 1 | Pulse from the protocol engine on entering bus-off |
| init_wr | input | 1 | Host write strobe for the init bit |
| init_wdata | input | 1 | Value the host writes to init |
| init_o | output | 1 | Current init bit state |
| lec_wr_stb | output | 1 | Strobe to write the last-error code |
| lec_wr_code | output | 3 | Code to write, 3'b101 (bit0 error) when strobed |
| rec_seq_cnt | output | SEQ_W (8) | Completed recessive runs in this recovery |
| err_cnt_clr | output | 1 | One-cycle pulse resetting the error counters at completion |

## Verification
If the consecutive-recessive counter holds a wrong value, the fault shows up at the next run boundary. `lec_wr_stb` fires early or late by the number of miscounted bits, within at most eleven bit strobes. A sequence counter that is off by one moves the `err_cnt_clr` pulse by a whole run, and `rec_seq_cnt` shows the fault on the very next increment. A control state stuck in halt or in normal shows immediately: either `rec_seq_cnt` stays at zero while bits are driven, or a host write changes `init_o` when it should have been ignored.

// File: rtl/bor_pkg.sv
package bor_pkg;
   typedef enum logic [1:0] {
      ST_NORMAL = 2'd0,
      ST_HALT   = 2'd1,
      ST_RECOV  = 2'd2
   } bor_state_t;

   localparam logic [2:0] LEC_BIT0 = 3'b101;
endpackage

// File: rtl/bor_run_det.sv
module bor_run_det #(
   parameter int RUN_LEN = 11,
   parameter bit RECESSIVE_LVL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic bit_stb,
   input  logic bus_bit,
   output logic run_done
);
   localparam int RUN_W = (RUN_LEN > 2) ? $clog2(RUN_LEN) : 1;
   localparam logic [RUN_W-1:0] RUN_LAST = RUN_W'(RUN_LEN - 1);

   logic is_rec;
   logic [RUN_W-1:0] run_q;

   generate
      if (RUN_LEN < 2) begin : g_bad_len
         $error("bor_run_det: RUN_LEN must be at least 2");
      end
      if (RECESSIVE_LVL) begin : g_rec_high
         assign is_rec = bus_bit;
      end else begin : g_rec_low
         assign is_rec = ~bus_bit;
      end
   endgenerate

   assign run_done = en && bit_stb && is_rec && (run_q == RUN_LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q <= '0;
      end else if (!en) begin
         run_q <= '0;
      end else if (bit_stb) begin
         if (!is_rec || run_done) begin
            run_q <= '0;
         end else begin
            run_q <= run_q + 1'b1;
         end
      end
   end
endmodule

// File: rtl/bor_seq_cnt.sv
module bor_seq_cnt #(
   parameter int RUN_COUNT = 129,
   parameter int SEQ_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             inc,
   output logic [SEQ_W-1:0] cnt,
   output logic             last
);
   localparam logic [SEQ_W-1:0] CNT_LAST = SEQ_W'(RUN_COUNT - 1);

   generate
      if (RUN_COUNT < 1) begin : g_bad_count
         $error("bor_seq_cnt: RUN_COUNT must be at least 1");
      end
      if ((1 << SEQ_W) <= RUN_COUNT) begin : g_bad_width
         $error("bor_seq_cnt: SEQ_W too narrow for RUN_COUNT");
      end
   endgenerate

   logic [SEQ_W-1:0] cnt_q;

   assign last = inc && (cnt_q == CNT_LAST);
   assign cnt  = cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (clr || last) begin
         cnt_q <= '0;
      end else if (inc) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end
endmodule

// File: rtl/bor_ctrl.sv
module bor_ctrl
   import bor_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic busoff_enter,
   input  logic init_wr,
   input  logic init_wdata,
   input  logic seq_last,
   output logic init_o,
   output logic recovering
);
   bor_state_t state_q;
   logic       init_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_NORMAL;
         init_q  <= 1'b0;
      end else if (busoff_enter) begin
         state_q <= ST_HALT;
         init_q  <= 1'b1;
      end else begin
         unique case (state_q)
            ST_NORMAL: begin
               if (init_wr) init_q <= init_wdata;
            end
            ST_HALT: begin
               if (init_wr && !init_wdata) begin
                  init_q  <= 1'b0;
                  state_q <= ST_RECOV;
               end
            end
            ST_RECOV: begin
               if (seq_last) state_q <= ST_NORMAL;
            end
            default: state_q <= ST_NORMAL;
         endcase
      end
   end

   assign init_o     = init_q;
   assign recovering = (state_q == ST_RECOV);
endmodule

// File: rtl/bor_recovery.sv
module bor_recovery
   import bor_pkg::*;
#(
   parameter int RUN_LEN = 11,
   parameter int RUN_COUNT = 129,
   parameter bit RECESSIVE_LVL = 1'b1,
   parameter int SEQ_W = $clog2(RUN_COUNT + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bit_stb,
   input  logic             bus_bit,
   input  logic             busoff_enter,
   input  logic             init_wr,
   input  logic             init_wdata,
   output logic             init_o,
   output logic             lec_wr_stb,
   output logic [2:0]       lec_wr_code,
   output logic [SEQ_W-1:0] rec_seq_cnt,
   output logic             err_cnt_clr
);
   logic recovering;
   logic run_done;
   logic seq_last;
   logic inc;

   bor_ctrl u_ctrl (
      .clk         (clk),
      .rst_n       (rst_n),
      .busoff_enter(busoff_enter),
      .init_wr     (init_wr),
      .init_wdata  (init_wdata),
      .seq_last    (seq_last),
      .init_o      (init_o),
      .recovering  (recovering)
   );

   bor_run_det #(
      .RUN_LEN      (RUN_LEN),
      .RECESSIVE_LVL(RECESSIVE_LVL)
   ) u_run (
      .clk     (clk),
      .rst_n   (rst_n),
      .en      (recovering && !busoff_enter),
      .bit_stb (bit_stb),
      .bus_bit (bus_bit),
      .run_done(run_done)
   );

   assign inc = run_done;

   bor_seq_cnt #(
      .RUN_COUNT(RUN_COUNT),
      .SEQ_W    (SEQ_W)
   ) u_seq (
      .clk  (clk),
      .rst_n(rst_n),
      .clr  (busoff_enter),
      .inc  (inc),
      .cnt  (rec_seq_cnt),
      .last (seq_last)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lec_wr_stb  <= 1'b0;
         lec_wr_code <= 3'b000;
         err_cnt_clr <= 1'b0;
      end else begin
         lec_wr_stb  <= inc;
         lec_wr_code <= inc ? LEC_BIT0 : 3'b000;
         err_cnt_clr <= seq_last;
      end
   end
endmodule

// File: rtl/bor_recovery_chk.sv
module bor_recovery_chk #(
   parameter int RUN_COUNT = 129,
   parameter int SEQ_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             busoff_enter,
   input logic             init_o,
   input logic             lec_wr_stb,
   input logic [SEQ_W-1:0] rec_seq_cnt,
   input logic             err_cnt_clr
);
   AST_BUSOFF_SETS_INIT: assert property (@(posedge clk) disable iff (!rst_n)
      busoff_enter |=> init_o); // R2

   AST_NO_COUNT_WHILE_INIT: assert property (@(posedge clk) disable iff (!rst_n)
      lec_wr_stb |-> !init_o); // R3

   AST_STEP_ON_RUN: assert property (@(posedge clk) disable iff (!rst_n)
      (lec_wr_stb && !err_cnt_clr) |-> (rec_seq_cnt == $past(rec_seq_cnt) + 1'b1)); // R5

   AST_HOLD_WITHOUT_RUN: assert property (@(posedge clk) disable iff (!rst_n)
      !lec_wr_stb |-> ($stable(rec_seq_cnt) || rec_seq_cnt == '0)); // R6

   AST_CLR_WITH_LAST_RUN: assert property (@(posedge clk) disable iff (!rst_n)
      err_cnt_clr |-> (lec_wr_stb && rec_seq_cnt == '0)); // R9

   AST_CLR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      err_cnt_clr |=> !err_cnt_clr); // R9

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      rec_seq_cnt <= SEQ_W'(RUN_COUNT - 1)); // R9
endmodule

bind bor_recovery bor_recovery_chk #(
   .RUN_COUNT(RUN_COUNT),
   .SEQ_W    (SEQ_W)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .busoff_enter(busoff_enter),
   .init_o      (init_o),
   .lec_wr_stb  (lec_wr_stb),
   .rec_seq_cnt (rec_seq_cnt),
   .err_cnt_clr (err_cnt_clr)
);

// File: tb/bor_recovery_test.sv
module bor_recovery_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bit_stb = 1'b0;
   logic       bus_bit = 1'b1;
   logic       busoff_enter = 1'b0;
   logic       init_wr = 1'b0;
   logic       init_wdata = 1'b0;
   logic       init_o;
   logic       lec_wr_stb;
   logic [2:0] lec_wr_code;
   logic [7:0] rec_seq_cnt;
   logic       err_cnt_clr;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   bor_recovery uut (
      .clk         (clk),
      .rst_n       (rst_n),
      .bit_stb     (bit_stb),
      .bus_bit     (bus_bit),
      .busoff_enter(busoff_enter),
      .init_wr     (init_wr),
      .init_wdata  (init_wdata),
      .init_o      (init_o),
      .lec_wr_stb  (lec_wr_stb),
      .lec_wr_code (lec_wr_code),
      .rec_seq_cnt (rec_seq_cnt),
      .err_cnt_clr (err_cnt_clr)
   );

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      bit_stb = 1'b0; busoff_enter = 1'b0; init_wr = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic send_bit(input logic v);
      bus_bit = v; bit_stb = 1'b1;
      @(negedge clk);
      bit_stb = 1'b0;
   endtask

   task automatic host_write(input logic v);
      init_wr = 1'b1; init_wdata = v;
      @(negedge clk);
      init_wr = 1'b0;
   endtask

   task automatic enter_busoff();
      busoff_enter = 1'b1;
      @(negedge clk);
      busoff_enter = 1'b0;
   endtask

   // send n recessive bits, return how many strobes of lec_wr_stb were seen
   task automatic send_rec(input int n, output int pulses);
      pulses = 0;
      for (int i = 0; i < n; i++) begin
         send_bit(1'b1);
         if (lec_wr_stb) pulses++;
      end
   endtask

   task automatic t_reset();
      do_reset();
      check("R1 init_o", int'(init_o), 0);
      check("R1 rec_seq_cnt", int'(rec_seq_cnt), 0);
      check("R1 strobes", int'({lec_wr_stb, err_cnt_clr}), 0);
      check("R1 lec_wr_code", int'(lec_wr_code), 0);
   endtask

   task automatic t_normal_write();
      do_reset();
      host_write(1'b1);
      check("R12 write 1", int'(init_o), 1);
      host_write(1'b0);
      check("R12 write 0", int'(init_o), 0);
   endtask

   task automatic t_halt();
      int p;
      do_reset();
      init_wr = 1'b1; init_wdata = 1'b0; busoff_enter = 1'b1;
      @(negedge clk);
      init_wr = 1'b0; busoff_enter = 1'b0;
      check("R2 init set over host clear", int'(init_o), 1);
      send_rec(25, p);
      check("R3 no strobe while halted", p, 0);
      check("R3 count held at zero", int'(rec_seq_cnt), 0);
      host_write(1'b1);
      check("R4 write 1 keeps halt", int'(init_o), 1);
      send_rec(11, p);
      check("R4 still not counting", int'(rec_seq_cnt), 0);
      host_write(1'b0);
      check("R4 write 0 clears init", int'(init_o), 0);
      send_rec(10, p);
      check("R5 no strobe before 11th", p, 0);
      send_bit(1'b1);
      check("R5 strobe on 11th", int'(lec_wr_stb), 1);
      check("R5 code bit0", int'(lec_wr_code), 5);
      check("R5 count 1", int'(rec_seq_cnt), 1);
      @(negedge clk);
      check("R5 strobe single cycle", int'(lec_wr_stb), 0);
   endtask

   task automatic start_recovery();
      do_reset();
      enter_busoff();
      host_write(1'b0);
   endtask

   task automatic t_dominant();
      int p;
      start_recovery();
      send_rec(10, p);
      send_bit(1'b0);
      check("R6 dominant no strobe", int'(lec_wr_stb), 0);
      check("R6 count unchanged", int'(rec_seq_cnt), 0);
      send_rec(10, p);
      check("R6 run restarted, 10 not enough", p, 0);
      send_bit(1'b1);
      check("R6 11th after dominant", int'(rec_seq_cnt), 1);
   endtask

   task automatic t_no_overlap();
      int p;
      start_recovery();
      send_rec(22, p);
      check("R7 two pulses in 22 bits", p, 2);
      check("R7 count two", int'(rec_seq_cnt), 2);
      send_rec(10, p);
      check("R7 partial third run", int'(rec_seq_cnt), 2);
   endtask

   task automatic t_gaps();
      int p;
      start_recovery();
      send_rec(5, p);
      bus_bit = 1'b0;
      repeat (4) @(negedge clk);
      send_rec(5, p);
      check("R8 no run before 11 strobed bits", int'(rec_seq_cnt), 0);
      send_bit(1'b1);
      check("R8 gaps ignored, run completes", int'(rec_seq_cnt), 1);
   endtask

   task automatic t_ignore_init();
      int p;
      start_recovery();
      send_rec(6, p);
      host_write(1'b1);
      check("R10 write ignored", int'(init_o), 0);
      send_rec(5, p);
      check("R10 run kept after write", int'(rec_seq_cnt), 1);
      host_write(1'b0);
      check("R10 clear keeps count", int'(rec_seq_cnt), 1);
   endtask

   task automatic t_reenter();
      int p;
      start_recovery();
      send_rec(33, p);
      check("R11 before re-entry", int'(rec_seq_cnt), 3);
      enter_busoff();
      check("R11 init set again", int'(init_o), 1);
      check("R11 count cleared", int'(rec_seq_cnt), 0);
      send_rec(11, p);
      check("R11 halted again", p, 0);
   endtask

   task automatic t_full();
      int p;
      int bad = 0;
      start_recovery();
      for (int r = 0; r < 128; r++) begin
         send_rec(11, p);
         if (p != 1 || rec_seq_cnt != 8'(r + 1) || err_cnt_clr) bad++;
      end
      check("R9 128 runs counted cleanly", bad, 0);
      check("R9 count at 128", int'(rec_seq_cnt), 128);
      send_rec(10, p);
      check("R9 no clear before last bit", int'(err_cnt_clr), 0);
      send_bit(1'b1);
      check("R9 clear pulse", int'(err_cnt_clr), 1);
      check("R9 last run strobes lec", int'(lec_wr_stb), 1);
      check("R9 count back to zero", int'(rec_seq_cnt), 0);
      @(negedge clk);
      check("R9 clear single cycle", int'(err_cnt_clr), 0);
      send_rec(11, p);
      check("R9 recovery ended", p, 0);
      host_write(1'b1);
      check("R9 normal writes resume", int'(init_o), 1);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog actual 0 expected 1");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      t_reset();
      t_normal_write();
      t_halt();
      t_dominant();
      t_no_overlap();
      t_gaps();
      t_ignore_init();
      t_reenter();
      t_full();
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule